// File: doc/BRIEF.md
# Register Read Guard Cache

This block sits next to a processor register file and protects register reads against transient upsets. It keeps a small, fully associative set of recently written register values. Each kept value carries an 8-bit CRC computed at the moment it was written. Every register write is copied into this set. Every register read looks the index up. A read that finds a cached copy compares that copy with what the register file returned. When the two disagree, the block holds the pipeline for one cycle and recomputes the CRC of the cached copy to decide which of the two to trust.

When the cached copy still matches its CRC, the register file is taken to be the corrupted side. The cached value is then delivered and an error pulse is raised. When the cached copy fails its own CRC, the register file value is delivered and the damaged entry is dropped. A read that finds no copy passes the register file data straight through.

A fault-emulation input lets an environment flip bits in a stored copy, so that a damaged cache entry can be modelled.

Top module: `regval_guard`

## Requirements
- R1: `rst_n` is active low and sampled on the rising clock edge. While it is low, every entry is emptied and `rd_valid`, `rd_error` and `stall` are 0. After reset, no register is cached, so a read whose data disagrees with an earlier write produces no stall.
- R2: A write (`wr_en`=1) stores the data together with its CRC-8 into the entry for `wr_addr`. The CRC uses polynomial x^8+x^2+x+1, a zero start value, and processes the data most significant bit first. A write to a register that is already cached updates that entry in place.
- R3: A write to a register that is not cached fills the entries in fixed rotation order and overwrites the oldest allocation. The number of entries `ENTRIES` is a parameter from 6 to 16. An in-place update does not advance the rotation.
- R4: An accepted read (`rd_en`=1 with `stall`=0) of a register that is not cached returns `rf_rd_data` on `rd_data` with `rd_valid`=1 in the next cycle. It raises neither `stall` nor `rd_error`.
- R5: An accepted read that finds a cached copy equal to `rf_rd_data` returns that data in the next cycle, without a stall or an error.
- R6: An accepted read that finds a cached copy differing from `rf_rd_data` produces `stall`=1 with `rd_valid`=0 in the next cycle, and the result in the cycle after that. `stall` is never high for two cycles in a row. A read presented while `stall` is high is ignored.
- R7: When the stored CRC still matches the cached copy, the check returns the cached value with `rd_error`=1 for one cycle.
- R8: When the stored CRC does not match the cached copy, the check returns the register file value captured at the read, with `rd_error`=0. The entry is also dropped, so later reads of that register are passed through. A write to that entry in the read cycle or in the check cycle keeps it.
- R9: When `upset_en` is 1 and `upset_addr` is cached, `upset_mask` is XORed into the stored value but not into its CRC. A write to the same entry in the same cycle takes precedence.
- R10: A read and a write in the same cycle see the cache contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index being written |
| wr_data | input | DATA_W | Data being written |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register index being read |
| rf_rd_data | input | DATA_W | Data returned by the register file for `rd_addr` |
| upset_en | input | 1 | Fault emulation: flip bits of a cached copy |
| upset_addr | input | ADDR_W | Register whose cached copy is flipped |
| upset_mask | input | DATA_W | Bits to flip |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Checked or corrected read result |
| rd_error | output | 1 | Register file copy judged corrupt |
| stall | output | 1 | Check cycle in progress, reads not accepted |

## Verification
The hardest case to reach is the path where the cached copy itself is wrong. A normal write always stores matching data and CRC, so this path cannot arise from writes alone. The bench first uses the upset input to damage a cached copy. It then issues a read whose register file data differs from the damaged copy, which drives the block down the drop-the-entry branch. A second read of the same register then shows the entry is gone, because the result passes through without a stall. Rotation replacement is reached by filling every entry, rewriting one register in place, and then adding two new registers, which shows exactly which registers were evicted.

// File: rtl/rvg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the register read guard.
// Assumes: a single clock domain; the CRC polynomial is given without its top term.
package rvg_pkg;

    // Controller phases: accepting reads, or resolving a disagreement
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CHECK = 1'b1
    } rvg_state_e;

    // x^8 + x^2 + x + 1, top term implied
    localparam logic [7:0] RVG_CRC8_POLY = 8'h07;

endpackage

// File: rtl/rvg_crc.sv
`timescale 1ns/1ps
// Combinational CRC over one data word, MSB first, zero start value.
// Assumes: CRC_W >= 2; POLY omits the x^CRC_W term.
module rvg_crc #(
    parameter int              DATA_W = 32,
    parameter int              CRC_W  = 8,
    parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    logic [CRC_W-1:0] acc;
    logic             fb;

    // Serial division unrolled into a chain of XOR stages
    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data_i[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end

endmodule

// File: rtl/rvg_store.sv
`timescale 1ns/1ps
// Entry storage: valid bits, register tags, values and CRCs.
// Provides associative lookups for read, write and upset, and rotation allocation.
// Assumes: at most one entry per register tag, which the write path maintains.
module rvg_store #(
    parameter int ENTRIES = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int CRC_W   = 8,
    parameter int SLOT_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // read lookup
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_hit_o,
    output logic [SLOT_W-1:0] rd_slot_o,
    output logic [DATA_W-1:0] rd_val_o,
    output logic [CRC_W-1:0]  rd_crc_o,
    // write
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [CRC_W-1:0]  wr_crc_i,
    output logic [SLOT_W-1:0] wr_slot_o,
    // fault emulation
    input  logic              up_en_i,
    input  logic [ADDR_W-1:0] up_addr_i,
    input  logic [DATA_W-1:0] up_mask_i,
    // invalidation from the checker
    input  logic              inv_en_i,
    input  logic [SLOT_W-1:0] inv_slot_i
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld_q;
    logic [ADDR_W-1:0]  tag_q [ENTRIES];
    logic [DATA_W-1:0]  val_q [ENTRIES];
    logic [CRC_W-1:0]   crc_q [ENTRIES];
    logic [SLOT_W-1:0]  ptr_q;

    logic [ENTRIES-1:0] rd_match, wr_match, up_match;
    logic               wr_hit, up_hit;
    logic [SLOT_W-1:0]  up_slot;

    // Encode a one-hot match vector into a slot number
    function automatic logic [SLOT_W-1:0] slot_of(input logic [ENTRIES-1:0] v);
        logic [SLOT_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (v[i]) idx = SLOT_W'(i);
        end
        return idx;
    endfunction

    // One comparator per entry for each of the three lookups
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign rd_match[g] = vld_q[g] && (tag_q[g] == rd_addr_i);
        assign wr_match[g] = vld_q[g] && (tag_q[g] == wr_addr_i);
        assign up_match[g] = vld_q[g] && (tag_q[g] == up_addr_i);
    end

    // Lookup results and target slot selection
    always_comb begin
        rd_hit_o  = |rd_match;
        rd_slot_o = slot_of(rd_match);
        rd_val_o  = val_q[rd_slot_o];
        rd_crc_o  = crc_q[rd_slot_o];
        wr_hit    = |wr_match;
        wr_slot_o = wr_hit ? slot_of(wr_match) : ptr_q;
        up_hit    = |up_match;
        up_slot   = slot_of(up_match);
    end

    // Valid bits and the rotation pointer; a write overrides a same-cycle drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            if (inv_en_i) begin
                vld_q[inv_slot_i] <= 1'b0;
            end
            if (wr_en_i) begin
                vld_q[wr_slot_o] <= 1'b1;
                if (!wr_hit) begin
                    ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
                end
            end
        end
    end

    // Entry payload; an upset is applied first so a same-cycle write wins
    always_ff @(posedge clk) begin
        if (up_en_i && up_hit) begin
            val_q[up_slot] <= val_q[up_slot] ^ up_mask_i;
        end
        if (wr_en_i) begin
            tag_q[wr_slot_o] <= wr_addr_i;
            val_q[wr_slot_o] <= wr_data_i;
            crc_q[wr_slot_o] <= wr_crc_i;
        end
    end

    // R2: one register never occupies two entries
    assert_rd_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match));
    assert_wr_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_match));
    // R3: the rotation pointer stays inside the entry range
    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < ENTRIES);
    // R3: an in-place update leaves the rotation pointer alone
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_hit) |=> $stable(ptr_q));

endmodule

// File: rtl/rvg_ctrl.sv
`timescale 1ns/1ps
// Read path controller: passes, checks or corrects a register read.
// On a disagreement it captures both copies, stalls one cycle, and lets the
// recomputed CRC of the cached copy pick the result.
// Assumes: chk_crc_i is the CRC of cap_val_o, computed combinationally outside.
module rvg_ctrl
    import rvg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CRC_W  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] rf_data_i,
    input  logic              rd_hit_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    input  logic [DATA_W-1:0] rd_val_i,
    input  logic [CRC_W-1:0]  rd_crc_i,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [CRC_W-1:0]  chk_crc_i,
    output logic [DATA_W-1:0] cap_val_o,
    output logic              inv_en_o,
    output logic [SLOT_W-1:0] inv_slot_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              err_o,
    output logic              stall_o
);

    rvg_state_e        state_q;
    logic [DATA_W-1:0] cap_val_q, cap_rf_q;
    logic [CRC_W-1:0]  cap_crc_q;
    logic [SLOT_W-1:0] cap_slot_q;
    logic              cap_dirty_q;

    logic accept, mismatch, crc_good, slot_rewritten;

    // Decode the current cycle's read and check conditions
    always_comb begin
        accept         = (state_q == ST_IDLE) && rd_en_i;
        mismatch       = accept && rd_hit_i && (rd_val_i != rf_data_i);
        crc_good       = (chk_crc_i == cap_crc_q);
        slot_rewritten = wr_en_i && (wr_slot_i == cap_slot_q);
        inv_en_o       = (state_q == ST_CHECK) && !crc_good
                         && !cap_dirty_q && !slot_rewritten;
        inv_slot_o     = cap_slot_q;
        cap_val_o      = cap_val_q;
        stall_o        = (state_q == ST_CHECK);
    end

    // Phase register and registered read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rd_valid_o <= 1'b0;
            err_o      <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= 1'b0;
            err_o      <= 1'b0;
            if (state_q == ST_CHECK) begin
                state_q    <= ST_IDLE;
                rd_valid_o <= 1'b1;
                rd_data_o  <= crc_good ? cap_val_q : cap_rf_q;
                err_o      <= crc_good;
            end else if (mismatch) begin
                state_q <= ST_CHECK;
            end else if (accept) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= rf_data_i;
            end
        end
    end

    // Capture both copies when a disagreement is seen
    always_ff @(posedge clk) begin
        if (mismatch) begin
            cap_val_q   <= rd_val_i;
            cap_crc_q   <= rd_crc_i;
            cap_rf_q    <= rf_data_i;
            cap_slot_q  <= rd_slot_i;
            cap_dirty_q <= wr_en_i && (wr_slot_i == rd_slot_i);
        end
    end

    // R6: the check lasts exactly one cycle
    assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);
    // R6: the result follows the stall cycle
    assert_stall_resolves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |=> rd_valid_o);
    // R6: no result is presented during the stall cycle
    assert_stall_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !rd_valid_o);
    // R7: an error pulse only comes with a result
    assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> rd_valid_o);
    // R7: an error pulse only ends a check cycle
    assert_err_after_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(stall_o));

endmodule

// File: rtl/regval_guard.sv
`timescale 1ns/1ps
// Register read guard cache: keeps CRC-protected copies of recently written
// registers and uses them to check, and if needed correct, register reads.
// Assumes: rf_rd_data belongs to rd_addr in the same cycle; ENTRIES is 6..16.
module regval_guard #(
    parameter int         ENTRIES  = 8,
    parameter int         DATA_W   = 32,
    parameter int         ADDR_W   = 5,
    parameter int         CRC_W    = 8,
    parameter logic [7:0] CRC_POLY = rvg_pkg::RVG_CRC8_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    input  logic              upset_en,
    input  logic [ADDR_W-1:0] upset_addr,
    input  logic [DATA_W-1:0] upset_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_error,
    output logic              stall
);

    localparam int SLOT_W = $clog2(ENTRIES);

    logic [CRC_W-1:0]  wr_crc, chk_crc, rd_crc;
    logic              rd_hit, inv_en;
    logic [SLOT_W-1:0] rd_slot, wr_slot, inv_slot;
    logic [DATA_W-1:0] rd_val, cap_val;

    // CRC of the incoming write data
    rvg_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY[CRC_W-1:0])) u_wr_crc (
        .data_i (wr_data),
        .crc_o  (wr_crc)
    );

    // CRC recomputed over the captured cached copy during the check cycle
    rvg_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY[CRC_W-1:0])) u_chk_crc (
        .data_i (cap_val),
        .crc_o  (chk_crc)
    );

    rvg_store #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .CRC_W   (CRC_W),
        .SLOT_W  (SLOT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr_i  (rd_addr),
        .rd_hit_o   (rd_hit),
        .rd_slot_o  (rd_slot),
        .rd_val_o   (rd_val),
        .rd_crc_o   (rd_crc),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .wr_crc_i   (wr_crc),
        .wr_slot_o  (wr_slot),
        .up_en_i    (upset_en),
        .up_addr_i  (upset_addr),
        .up_mask_i  (upset_mask),
        .inv_en_i   (inv_en),
        .inv_slot_i (inv_slot)
    );

    rvg_ctrl #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .SLOT_W (SLOT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en),
        .rf_data_i  (rf_rd_data),
        .rd_hit_i   (rd_hit),
        .rd_slot_i  (rd_slot),
        .rd_val_i   (rd_val),
        .rd_crc_i   (rd_crc),
        .wr_en_i    (wr_en),
        .wr_slot_i  (wr_slot),
        .chk_crc_i  (chk_crc),
        .cap_val_o  (cap_val),
        .inv_en_o   (inv_en),
        .inv_slot_o (inv_slot),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data),
        .err_o      (rd_error),
        .stall_o    (stall)
    );

    // R4: a read with no cached copy never stalls
    assert_miss_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !stall && !rd_hit) |=> !stall);
    // R8: a dropped entry is never the one being checked next cycle
    assert_inv_ends_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !stall);

endmodule

// File: tb/sim_regval_guard.sv
`timescale 1ns/1ps
// Bench for regval_guard: a behavioural model predicts every output each clock.
module sim_regval_guard;

    localparam int N  = 8;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, upset_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, upset_addr = '0;
    logic [DW-1:0] wr_data = '0, rf_rd_data = '0, upset_mask = '0;
    logic          rd_valid, rd_error, stall;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    regval_guard #(.ENTRIES(N), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rf_rd_data(rf_rd_data),
        .upset_en(upset_en), .upset_addr(upset_addr), .upset_mask(upset_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_error(rd_error), .stall(stall)
    );

    // model state
    bit        m_vld [N];
    int        m_reg [N];
    bit [31:0] m_val [N];
    bit        m_bad [N];
    int        m_ptr;
    bit        m_chk, c_bad, c_dirty;
    int        c_slot;
    bit [31:0] c_val, c_rf;
    bit        e_valid, e_err, e_stall;
    bit [31:0] e_data;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    function automatic int find(input int r);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_reg[i] == r) return i;
        return -1;
    endfunction

    // Advance the model by one rising edge using the inputs currently driven
    task automatic model_edge();
        int ws, rs, us, inv;
        bit nv, ne;
        bit [31:0] nd;
        nv = 0; ne = 0; nd = e_data; inv = -1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
            m_ptr = 0; m_chk = 0;
            e_valid = 0; e_err = 0; e_stall = 0; e_data = 0;
            return;
        end
        ws = find(int'(wr_addr));
        if (ws < 0) ws = m_ptr;
        rs = find(int'(rd_addr));
        us = find(int'(upset_addr));
        if (m_chk) begin
            nv = 1; m_chk = 0;
            if (!c_bad) begin nd = c_val; ne = 1; end
            else begin
                nd = c_rf;
                if (!c_dirty && !(wr_en && ws == c_slot)) inv = c_slot;
            end
        end else if (rd_en) begin
            if (rs < 0 || m_val[rs] == rf_rd_data) begin nv = 1; nd = rf_rd_data; end
            else begin
                m_chk = 1; c_slot = rs; c_val = m_val[rs]; c_bad = m_bad[rs];
                c_rf = rf_rd_data; c_dirty = wr_en && (ws == rs);
            end
        end
        if (inv >= 0) m_vld[inv] = 0;
        if (upset_en && us >= 0) begin m_val[us] ^= upset_mask; m_bad[us] = 1; end
        if (wr_en) begin
            if (find(int'(wr_addr)) < 0 && !(ws == inv)) m_ptr = (m_ptr + 1) % N;
            else if (ws == inv && find(int'(wr_addr)) < 0) m_ptr = m_ptr;
            m_vld[ws] = 1; m_reg[ws] = int'(wr_addr); m_val[ws] = wr_data; m_bad[ws] = 0;
        end
        e_valid = nv; e_err = ne; e_stall = m_chk;
        if (nv) e_data = nd;
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("stall", 32'(stall), 32'(e_stall));
        chk("rd_valid", 32'(rd_valid), 32'(e_valid));
        chk("rd_error", 32'(rd_error), 32'(e_err));
        if (e_valid) chk("rd_data", rd_data, e_data);
    endtask

    // One clock: drive at the falling edge, model at the rising edge, compare after it
    task automatic step(input bit we, input int wa, input bit [31:0] wd,
                        input bit re, input int ra, input bit [31:0] rfd,
                        input bit ue = 0, input int ua = 0, input bit [31:0] um = 0);
        @(negedge clk);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd_en = re; rd_addr = AW'(ra); rf_rd_data = rfd;
        upset_en = ue; upset_addr = AW'(ua); upset_mask = um;
        @(posedge clk);
        model_edge();
        #1 compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        m_ptr = 0; m_chk = 0;
        // R1: reset state and reset clearing cached copies
        cur_req = "R1";
        do_reset();
        step(1, 4, 32'h0000_0111, 0, 0, 0);
        do_reset();
        step(0, 0, 0, 1, 4, 32'h0000_0999);   // not cached after reset: pass through
        idle(1);

        // R2 / R5: write then matching read; in-place update
        cur_req = "R5";
        step(1, 3, 32'h0000_1234, 0, 0, 0);
        step(0, 0, 0, 1, 3, 32'h0000_1234);
        cur_req = "R2";
        step(1, 3, 32'h0000_AAAA, 0, 0, 0);
        step(0, 0, 0, 1, 3, 32'h0000_AAAA);
        idle(1);

        // R4: miss passes through
        cur_req = "R4";
        step(0, 0, 0, 1, 9, 32'hCAFE_0009);
        idle(1);

        // R6 / R7: disagreement, cached copy intact; read during stall ignored
        cur_req = "R7";
        step(0, 0, 0, 1, 3, 32'hDEAD_BEEF);
        cur_req = "R6";
        step(0, 0, 0, 1, 9, 32'h1111_2222);
        idle(2);

        // R9 / R8: damage the cached copy, then disagree; entry then dropped
        cur_req = "R9";
        step(0, 0, 0, 0, 0, 0, 1, 3, 32'h0000_0010);
        cur_req = "R8";
        step(0, 0, 0, 1, 3, 32'h0000_AAAA);
        idle(2);
        step(0, 0, 0, 1, 3, 32'h5555_5555);   // dropped: pass through, no stall
        idle(1);

        // R9: write in the same cycle as an upset wins
        cur_req = "R9";
        step(1, 6, 32'h0000_0600, 0, 0, 0);
        step(1, 6, 32'h0000_0601, 0, 0, 0, 1, 6, 32'h0000_0004);
        step(0, 0, 0, 1, 6, 32'h0000_0777);   // cached copy intact: corrected
        idle(2);

        // R3: fill every entry, update one in place, add two new registers
        cur_req = "R3";
        do_reset();
        for (int r = 0; r < N; r++) step(1, r, 32'h100 + 32'(r), 0, 0, 0);
        step(1, 20, 32'h0000_0200, 0, 0, 0);  // evicts register 0
        step(1, 1, 32'h0000_0301, 0, 0, 0);   // in place
        step(1, 21, 32'h0000_0201, 0, 0, 0);  // evicts register 1
        step(0, 0, 0, 1, 0, 32'hFFFF_0000);
        step(0, 0, 0, 1, 1, 32'hFFFF_0001);
        step(0, 0, 0, 1, 2, 32'hFFFF_0002);   // still cached: stall
        idle(2);

        // R10: same-cycle write and read of one register see the old copy
        cur_req = "R10";
        step(1, 5, 32'h0000_0002, 1, 5, 32'h0000_0002);
        idle(2);

        // Mixed traffic across all paths
        cur_req = "R6";
        for (int i = 0; i < 400; i++) begin
            int ra, s;
            bit [31:0] rfd;
            ra = int'($urandom % 12);
            s = find(ra);
            rfd = ($urandom % 2 == 0 && s >= 0) ? m_val[s] : $urandom;
            step($urandom % 3 == 0, int'($urandom % 12), $urandom,
                 $urandom % 2 == 0, ra, rfd,
                 $urandom % 16 == 0, int'($urandom % 12), 32'h1 << ($urandom % 32));
        end
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule